// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It walks a tree of translation descriptors held in memory. A request carries the virtual address, a context number and the physical base of a context table. The walker then reads descriptor words one at a time over a plain physical read port, which needs no translation. It starts with the context table entry and can descend through up to three further table levels.

Each fetched word ends the walk or continues it. A page entry stops the walk with a mapping. A table pointer sends the walk one level deeper. Any other word ends the walk with a fault. Because a mapping can be found at any level, including the context entry itself, one entry can cover 4 GiB, 16 MiB, 256 KiB or 4 KiB.

The control is a three-state machine:
- `ST_IDLE`: waiting for a request.
- `ST_FETCH`: one read is outstanding.
- `ST_REPORT`: the one-cycle result strobe.

It has five named transitions:
- ACCEPT (`ST_IDLE` to `ST_FETCH`): a request is taken.
- DESCEND (`ST_FETCH` to `ST_FETCH`): a table pointer was read below the last level.
- MAP (`ST_FETCH` to `ST_REPORT`): a page entry was read.
- ABORT (`ST_FETCH` to `ST_REPORT`): an invalid or reserved word was read, or a pointer was read at the last level.
- RETIRE (`ST_REPORT` to `ST_IDLE`).

Top module: `tablewalk_unit`

## Requirements
- R1: `req_ready` is high only when the walker is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` while busy has no effect on the walk in progress and produces no extra result.
- R2: The first descriptor is read from `req_ctbase + 4*req_ctx`, computed in 36 bits.
- R3: Descriptor bits [1:0] give the entry type: 0 is invalid, 1 is a table pointer, 2 is a page entry, and 3 is reserved and treated as invalid.
- R4: A table pointer read at level L < 3 leads to a read at (word with bits [3:0] cleared) * 16 + 4 * index(L+1). The index for levels 1, 2 and 3 is virtual address bits [31:24], [23:18] and [17:12] respectively.
- R5: A page entry read at level L (0 to 3) gives `res_fault` = 0 and `res_level` = L. `res_paddr` is (word with bits [7:0] cleared) * 16, ORed with the zero-extended virtual address bits below bit 32, 24, 18 or 12 for L = 0, 1, 2 or 3.
- R6: An invalid or reserved word read at level L gives `res_fault` = 1, `res_paddr` = 0 and `res_level` = L.
- R7: A table pointer read at level 3 gives `res_fault` = 1, `res_paddr` = 0 and `res_level` = 3.
- R8: Only one read is outstanding at a time. `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_valid` is high, and that cycle consumes `mem_rdata`. A walk that ends at level L makes exactly L+1 reads.
- R9: `done` is high for exactly one cycle: the cycle after the edge that consumes the final descriptor. The result outputs are valid in that cycle.
- R10: A synchronous `rst` abandons any walk. After the next edge the walker is idle, with `mem_req` and `done` low, and no result from the abandoned walk ever appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request may be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ctx | input | 8 | Context number |
| req_ctbase | input | 36 | Physical base of the context table |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 36 | Physical address of the descriptor read |
| mem_valid | input | 1 | Read data present this cycle |
| mem_rdata | input | 32 | Descriptor word |
| done | output | 1 | One-cycle result strobe |
| res_paddr | output | 36 | Translated physical address (0 on a fault) |
| res_level | output | 2 | Level at which the walk ended |
| res_fault | output | 1 | Walk ended without a mapping |

## Verification
With memory latency d, every descriptor read costs d+1 cycles. The result strobe therefore rises exactly reads*(d+1) cycles after the edge that takes the request. The monitor records the cycle count of the accepting edge from `req_valid` and `req_ready` seen on the falling edge before it. When `done` is seen, it requires the elapsed edge count to equal the scoreboard item's computed latency. That latency is checked for memory latencies 0, 2 and 3. The read addresses and read count of each walk are logged on falling edges and compared in the same cycle in which `done` is seen.

// File: rtl/tablewalk_pkg.sv
package tablewalk_pkg;
    // descriptor and physical address geometry
    localparam int DESC_W  = 32;
    localparam int PA_W    = DESC_W + 4;   // descriptors are shifted up by four
    localparam int PFN_LSB = 12;           // where descriptor bit 8 lands
    localparam int LVL_W   = 2;
    localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;

    typedef enum logic [1:0] {
        ET_INVALID  = 2'd0,
        ET_TABLE    = 2'd1,
        ET_PAGE     = 2'd2,
        ET_RESERVED = 2'd3
    } entry_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_REPORT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/tw_decode.sv
// Splits a fetched descriptor into its type and the next table base.
module tw_decode
    import tablewalk_pkg::*;
(
    input  logic [DESC_W-1:0] word,
    output entry_kind_e       kind,
    output logic [PA_W-1:0]   table_base
);
    assign kind       = entry_kind_e'(word[1:0]);
    // pointer field (bits above 3) moved up four places into the 36-bit space
    assign table_base = {word & {{(DESC_W-4){1'b1}}, 4'h0}, 4'h0};
endmodule

// File: rtl/tw_addrgen.sv
// Descriptor address for each level; the walker picks one per read.
module tw_addrgen
    import tablewalk_pkg::*;
#(
    parameter int CTX_W  = 8,
    parameter int IDX1_W = 8,
    parameter int IDX2_W = 6,
    parameter int IDX3_W = 6
) (
    input  logic [PA_W-1:0]                   ctbase,
    input  logic [CTX_W-1:0]                  ctx,
    input  logic [IDX1_W+IDX2_W+IDX3_W-1:0]   vpn,
    input  logic [PA_W-1:0]                   table_base,
    input  logic [LVL_W-1:0]                  sel,
    output logic [PA_W-1:0]                   addr
);
    localparam int VPN_W = IDX1_W + IDX2_W + IDX3_W;

    logic [PA_W-1:0] cand [4];

    // level 0: entry in the context table
    assign cand[0] = ctbase + {{(PA_W-CTX_W-2){1'b0}}, ctx, 2'b00};

    for (genvar l = 1; l < 4; l++) begin : g_lvl
        localparam int W  = (l == 1) ? IDX1_W : (l == 2) ? IDX2_W : IDX3_W;
        localparam int LO = (l == 1) ? VPN_W - IDX1_W
                          : (l == 2) ? VPN_W - IDX1_W - IDX2_W
                          : 0;
        logic [W-1:0] idx;
        assign idx     = vpn[LO+W-1:LO];
        assign cand[l] = table_base + {{(PA_W-W-2){1'b0}}, idx, 2'b00};
    end

    assign addr = cand[sel];
endmodule

// File: rtl/tw_compose.sv
// Forms the physical address from a page entry and the untranslated offset.
module tw_compose
    import tablewalk_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int IDX1_W = 8,
    parameter int IDX2_W = 6,
    parameter int IDX3_W = 6
) (
    input  logic [DESC_W-1:0] pte_word,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [LVL_W-1:0]  level,
    output logic [PA_W-1:0]   paddr
);
    logic [VA_W-1:0] off [4];

    for (genvar l = 0; l < 4; l++) begin : g_off
        localparam int SH = (l == 0) ? VA_W
                          : (l == 1) ? VA_W - IDX1_W
                          : (l == 2) ? VA_W - IDX1_W - IDX2_W
                          : VA_W - IDX1_W - IDX2_W - IDX3_W;
        localparam logic [63:0] MASK = (64'd1 << SH) - 64'd1;
        assign off[l] = vaddr & MASK[VA_W-1:0];
    end

    assign paddr = {pte_word & {{(DESC_W-8){1'b1}}, 8'h00}, 4'h0}
                 | {{(PA_W-VA_W){1'b0}}, off[level]};
endmodule

// File: rtl/tablewalk_unit.sv
// Translation table walker: context entry plus up to three table levels.
module tablewalk_unit
    import tablewalk_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int CTX_W  = 8,
    parameter int IDX1_W = 8,
    parameter int IDX2_W = 6,
    parameter int IDX3_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [PA_W-1:0]   req_ctbase,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              done,
    output logic [PA_W-1:0]   res_paddr,
    output logic [LVL_W-1:0]  res_level,
    output logic              res_fault
);
    localparam int VPN_W   = IDX1_W + IDX2_W + IDX3_W;
    localparam int PAGE_SH = VA_W - VPN_W;

    walk_state_e      state_q, state_d;
    logic [VA_W-1:0]  vaddr_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  addr_q;
    logic [PA_W-1:0]  paddr_q;
    logic [LVL_W-1:0] hit_q;
    logic             fault_q;

    entry_kind_e      kind;
    logic [PA_W-1:0]  next_base;
    logic [PA_W-1:0]  walk_addr;
    logic [PA_W-1:0]  composed;
    logic [LVL_W-1:0] sel;
    logic             descend;

    tw_decode u_decode (
        .word       (mem_rdata),
        .kind       (kind),
        .table_base (next_base)
    );

    tw_addrgen #(
        .CTX_W  (CTX_W),
        .IDX1_W (IDX1_W),
        .IDX2_W (IDX2_W),
        .IDX3_W (IDX3_W)
    ) u_addrgen (
        .ctbase     (req_ctbase),
        .ctx        (req_ctx),
        .vpn        (vaddr_q[VA_W-1:PAGE_SH]),
        .table_base (next_base),
        .sel        (sel),
        .addr       (walk_addr)
    );

    tw_compose #(
        .VA_W   (VA_W),
        .IDX1_W (IDX1_W),
        .IDX2_W (IDX2_W),
        .IDX3_W (IDX3_W)
    ) u_compose (
        .pte_word (mem_rdata),
        .vaddr    (vaddr_q),
        .level    (level_q),
        .paddr    (composed)
    );

    // idle selects the context entry; otherwise the level below the current one
    assign sel     = (state_q == ST_IDLE) ? '0 : level_q + 2'd1;
    assign descend = (kind == ET_TABLE) && (level_q != LAST_LVL);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: ACCEPT, DESCEND, MAP, ABORT, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FETCH;
            ST_FETCH:  if (mem_valid) state_d = descend ? ST_FETCH : ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // walk and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_q <= '0;
            level_q <= '0;
            addr_q  <= '0;
            paddr_q <= '0;
            hit_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        level_q <= '0;
                        addr_q  <= walk_addr;
                    end
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        if (kind == ET_PAGE) begin
                            paddr_q <= composed;
                            hit_q   <= level_q;
                            fault_q <= 1'b0;
                        end else if (descend) begin
                            addr_q  <= walk_addr;
                            level_q <= level_q + 2'd1;
                        end else begin
                            paddr_q <= '0;
                            hit_q   <= level_q;
                            fault_q <= 1'b1;
                        end
                    end
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_FETCH);
    assign mem_addr  = addr_q;
    assign done      = (state_q == ST_REPORT);
    assign res_paddr = paddr_q;
    assign res_level = hit_q;
    assign res_fault = fault_q;
endmodule

// File: rtl/tablewalk_sva.sv
module tablewalk_sva
    import tablewalk_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_req,
    input logic            mem_valid,
    input logic [PA_W-1:0] mem_addr,
    input logic            done,
    input logic            res_fault,
    input logic [PA_W-1:0] res_paddr
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req && !done));                              // R1
    AST_ACCEPT_FETCH: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> mem_req);                           // R1
    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));     // R8
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && res_fault) |-> (res_paddr == '0));                      // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                 // R9
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_valid));                           // R9
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !mem_req && !done));                // R10
endmodule

bind tablewalk_unit tablewalk_sva u_sva (.*);

// File: tb/tablewalk_unit_test.sv
`timescale 1ns/1ps
module tablewalk_unit_test;
    import tablewalk_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_ctx = '0;
    logic [35:0] req_ctbase = '0;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_rdata;
    logic        done;
    logic [35:0] res_paddr;
    logic [1:0]  res_level;
    logic        res_fault;

    tablewalk_unit uut (.*);

    always #4 clk = ~clk;   // 125 MHz

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- memory model ----------------
    logic [31:0] mem [logic [35:0]];
    int mem_lat = 0;
    int wcnt = 0;

    function automatic logic [31:0] rd(input logic [35:0] a);
        if (mem.exists(a)) return mem[a];
        return '0;
    endfunction

    assign mem_valid = mem_req && (wcnt == mem_lat);
    assign mem_rdata = rd(mem_addr);
    always @(posedge clk) begin
        if (rst || !mem_req || mem_valid) wcnt <= 0;
        else                              wcnt <= wcnt + 1;
    end

    // ---------------- reference model from the requirements ----------------
    typedef struct packed {
        logic [35:0]       paddr;
        logic [1:0]        lvl;
        logic              fault;
        logic [2:0]        nrd;
        logic [3:0][35:0]  addrs;
        logic [31:0]       lat;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    function automatic logic [7:0] idx_of(input logic [31:0] va, input int l);
        case (l)
            1:       return va[31:24];
            2:       return {2'b00, va[23:18]};
            default: return {2'b00, va[17:12]};
        endcase
    endfunction

    function automatic logic [31:0] off_mask(input int l);
        case (l)
            0:       return 32'hFFFF_FFFF;
            1:       return 32'h00FF_FFFF;
            2:       return 32'h0003_FFFF;
            default: return 32'h0000_0FFF;
        endcase
    endfunction

    function automatic exp_t model(input logic [31:0] va, input logic [7:0] ctx,
                                   input logic [35:0] ctb, input int lat);
        exp_t e;
        logic [35:0] a;
        logic [31:0] w;
        bit fin;
        e   = '0;
        fin = 1'b0;
        a   = ctb + {26'd0, ctx, 2'b00};
        for (int step = 0; step < 4 && !fin; step++) begin
            e.addrs[step] = a;
            e.nrd = 3'(step + 1);
            e.lvl = 2'(step);
            w = rd(a);
            if (w[1:0] == 2'b10) begin
                e.paddr = {w[31:8], 12'h000} | {4'h0, va & off_mask(step)};
                fin = 1'b1;
            end else if (w[1:0] == 2'b01 && step < 3) begin
                a = {w[31:4], 8'h00} + {26'd0, idx_of(va, step + 1), 2'b00};
            end else begin
                e.fault = 1'b1;
                e.paddr = '0;
                fin = 1'b1;
            end
        end
        e.lat = 32'(int'(e.nrd) * (lat + 1));
        return e;
    endfunction

    function automatic logic [31:0] mkptd(input logic [35:0] base);
        return {base[35:8], 2'b00, 2'b01};
    endfunction

    function automatic logic [31:0] mkpte(input logic [35:0] pa);
        return {pa[35:12], 6'b000000, 2'b10};
    endfunction

    // ---------------- checking ----------------
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard when a result appears
    logic [3:0][35:0] seen;
    int          nseen = 0;
    int unsigned acc_cyc = 0;
    bit          prev_done = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            nseen     = 0;
            prev_done = 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                acc_cyc = cyc + 1;
                nseen   = 0;
            end
            if (mem_req && mem_valid) begin
                if (nseen < 4) seen[nseen] = mem_addr;
                nseen++;
            end
            if (done) begin
                exp_t  e;
                string t;
                if (prev_done)
                    chk(1'b0, "R9 done held over two cycles", 64'd1, 64'd0);
                else if (exp_q.size() == 0)
                    chk(1'b0, "R1 result without an accepted request", 64'd1, 64'd0);
                else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(res_paddr == e.paddr, {t, " paddr"}, 64'(res_paddr), 64'(e.paddr));
                    chk(res_level == e.lvl,   {t, " level"}, 64'(res_level), 64'(e.lvl));
                    chk(res_fault == e.fault, {t, " fault"}, 64'(res_fault), 64'(e.fault));
                    chk(nseen == int'(e.nrd), "R8 read count", 64'(nseen), 64'(e.nrd));
                    chk(seen[0] == e.addrs[0], "R2 first descriptor address",
                        64'(seen[0]), 64'(e.addrs[0]));
                    for (int k = 1; k < 4; k++)
                        if (k < int'(e.nrd))
                            chk(seen[k] == e.addrs[k], "R4 descriptor address",
                                64'(seen[k]), 64'(e.addrs[k]));
                    chk(cyc == acc_cyc + e.lat, "R9 result latency",
                        64'(cyc - acc_cyc), 64'(e.lat));
                end
            end
            prev_done = done;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [31:0] va, input logic [7:0] ctx,
                         input logic [35:0] ctb, input string tag);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(model(va, ctx, ctb, mem_lat));
        tag_q.push_back(tag);
        req_vaddr  = va;
        req_ctx    = ctx;
        req_ctbase = ctb;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [7:0] ctx,
                        input logic [35:0] ctb, input string tag);
        issue(va, ctx, ctb, tag);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [35:0] CTB  = 36'h0_0001_0000;
    localparam logic [35:0] CTB2 = 36'h0_0001_0FF0;
    localparam logic [35:0] T1   = 36'h0_0002_0000;
    localparam logic [35:0] T2   = 36'h0_0003_0000;
    localparam logic [35:0] T3   = 36'h0_0004_0000;

    localparam logic [31:0] VA_L1     = {8'h12, 24'h9A_BCDE};
    localparam logic [31:0] VA_L1INV  = {8'h56, 24'h00_0000};
    localparam logic [31:0] VA_L2     = {8'h34, 6'h0A, 18'h2_BCDE};
    localparam logic [31:0] VA_L2RES  = {8'h34, 6'h2A, 18'h0_0000};
    localparam logic [31:0] VA_L3     = {8'h34, 6'h15, 6'h01, 12'hF0F};
    localparam logic [31:0] VA_L3PTD  = {8'h34, 6'h15, 6'h3F, 12'h123};
    localparam logic [31:0] VA_L3INV  = {8'h34, 6'h15, 6'h20, 12'h000};

    initial begin
        mem[CTB + 36'd0]        = mkptd(T1);
        mem[CTB + 36'd4]        = mkpte(36'h9_0000_0000);
        mem[CTB + 36'd8]        = 32'h0000_0000;
        mem[CTB + 36'd12]       = 32'h1234_5673;
        mem[CTB2 + 36'h3FC]     = mkpte(36'h3_0000_0000);
        mem[T1 + 36'(4*8'h12)]  = mkpte(36'h5_A000_0000);
        mem[T1 + 36'(4*8'h34)]  = mkptd(T2);
        mem[T1 + 36'(4*8'h56)]  = 32'h0000_0000;
        mem[T2 + 36'(4*6'h0A)]  = mkpte(36'h6_1240_0000);
        mem[T2 + 36'(4*6'h15)]  = mkptd(T3);
        mem[T2 + 36'(4*6'h2A)]  = 32'hFFFF_FFF3;
        mem[T3 + 36'(4*6'h01)]  = mkpte(36'h7_ABCD_E000);
        mem[T3 + 36'(4*6'h3F)]  = mkptd(36'h0_0005_0000);
        mem[T3 + 36'(4*6'h20)]  = 32'h0000_0000;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready during reset", 64'(req_ready), 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 idle after reset", 64'(req_ready), 64'd1);
        chk(mem_req == 1'b0, "R10 no read after reset", 64'(mem_req), 64'd0);
        chk(done == 1'b0, "R10 no result after reset", 64'(done), 64'd0);

        // zero-latency memory
        mem_lat = 0;
        walk(32'hDEAD_BEEF, 8'd1, CTB, "R5 context-level page");
        walk(32'h0000_1000, 8'd2, CTB, "R6 invalid context entry");
        walk(32'h0000_1000, 8'd3, CTB, "R3 reserved context entry");
        walk(VA_L1,    8'd0, CTB, "R5 level-1 page");
        walk(VA_L2,    8'd0, CTB, "R5 level-2 page");
        walk(VA_L3,    8'd0, CTB, "R5 level-3 page");
        walk(VA_L3PTD, 8'd0, CTB, "R7 pointer at last level");
        walk(VA_L1INV, 8'd0, CTB, "R6 invalid level-1 entry");
        walk(VA_L2RES, 8'd0, CTB, "R3 reserved level-2 entry");
        walk(VA_L3INV, 8'd0, CTB, "R6 invalid level-3 entry");
        walk(32'h8765_4321, 8'd255, CTB2, "R2 high context carry");

        // slower memory
        mem_lat = 2;
        walk(VA_L3, 8'd0, CTB, "R8 level-3 page slow memory");
        walk(VA_L1, 8'd0, CTB, "R8 level-1 page slow memory");

        // requests while busy are ignored
        mem_lat = 3;
        issue(VA_L3, 8'd0, CTB, "R1 walk with busy requests");
        for (int i = 0; i < 6; i++) begin
            req_vaddr = 32'hDEAD_BEEF;
            req_ctx   = 8'd1;
            req_valid = 1'b1;
            @(negedge clk);
            chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
        end
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(req_ready == 1'b1, "R1 idle after busy requests", 64'(req_ready), 64'd1);

        // reset in the middle of a walk
        issue(VA_L3, 8'd0, CTB, "R10 abandoned walk");
        repeat (3) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, "R10 idle after mid-walk reset", 64'(req_ready), 64'd1);
        chk(mem_req == 1'b0, "R10 read dropped by reset", 64'(mem_req), 64'd0);
        chk(done == 1'b0, "R10 no result after mid-walk reset", 64'(done), 64'd0);
        repeat (30) @(negedge clk);
        walk(VA_L2, 8'd0, CTB, "R10 walk after reset");

        chk(exp_q.size() == 0, "R1 no result outstanding", 64'(exp_q.size()), 64'd0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        summary();
    end
endmodule